// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. The line rests high when idle. A one-deep holding stage sits in front of a shift stage, so a processor can queue the next character while the current one is still going out. Time is measured in ticks of a 16x enable input, and one bit cell lasts 16 ticks. The line-control inputs set the frame format: word length, parity, stick parity, stop-bit count and a forced break.

Two status outputs report the state of the pipeline. `thre` is high when the holding stage can accept a character. `temt` is high when both stages are empty. The line-control inputs are captured at the moment a character moves from the holding stage into the shift stage. They should only be changed while both status bits are high.

Top module: `sertx_dbuf`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `sout`, `thre` and `temt` are all 1.
- R2: A clock edge with `wr_en` high loads `wr_data` into the holding stage, and `thre` reads 0 after that edge. `temt` does not change at that edge.
- R3: The transfer happens on the first tick edge at which the holding stage is full and the shift stage is either idle or finishing its last stop tick. At that edge `thre` goes to 1, `temt` goes to 0 and `sout` starts the low start bit.
- R4: A character written while another is shifting stays in the holding stage. `thre` stays 0 and `temt` stays 0 until the current frame's final tick, and that final tick edge is the transfer edge of the queued character.
- R5: When a frame's final tick passes and the holding stage is empty, `temt` goes to 1 on that edge. `thre` is already 1 at that point.
- R6: The frame is sent in this order: a start bit at 0, then the data bits from bit 0 upward, then the optional parity bit, then the stop bits at 1. Each bit lasts 16 ticks. `wlen` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Unused upper bits of `wr_data` are not sent.
- R7: With `par_en`=1 and `par_stick`=0, a parity bit follows the data. `par_even`=1 makes the number of ones in the data bits plus the parity bit even. `par_even`=0 makes that number odd.
- R8: With `par_en`=1 and `par_stick`=1, the parity bit equals the inverse of `par_even`.
- R9: The stop interval is 16 ticks when `stop2`=0. It is 24 ticks when `stop2`=1 and `wlen`=0, and 32 ticks when `stop2`=1 with any other word length.
- R10: While `brk` is 1, `sout` is 0 from the next clock edge onward. After `brk` returns to 0, `sout` shows the normal line level from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable at 16 times the bit rate, one clock wide |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Character to send |
| wlen | input | 2 | Word length code (0..3 gives 5..8 bits) |
| stop2 | input | 1 | Longer stop interval select |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Stick parity enable |
| brk | input | 1 | Force the line low |
| sout | output | 1 | Serial output, idle high |
| thre | output | 1 | Holding stage empty |
| temt | output | 1 | Holding and shift stages both empty |

## Verification
The hardest state to reach from the ports is a full holding stage while the shift stage is still mid-frame. In that state the queued character must not move before the exact final tick of the frame, and `temt` must not pulse high in between. The bench writes a second character right after the first one transfers. It then counts 16x ticks until `thre` rises again, and this count must equal the first frame's length. Every frame format is sent as such a back-to-back pair, so a stop interval that is too long or too short shows up as a misplaced start bit in the second frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Line settings captured at each holding-to-shift transfer
  typedef struct packed {
    logic [1:0] wlen;
    logic       stop2;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } sertx_lc_t;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer,
  output logic [DATA_W-1:0] hold_data,
  output logic              thre
);

  // Data register carries no reset; only the empty flag does
  always_ff @(posedge clk) begin
    if (wr_en) hold_data <= wr_data;
  end

  // A write wins over a transfer on the same edge
  always_ff @(posedge clk) begin
    if (rst)        thre <= 1'b1;
    else if (wr_en) thre <= 1'b0;
    else if (xfer)  thre <= 1'b1;
  end

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OVS     = 16,
  parameter int FRAME_W = DATA_W + 2,
  parameter int CNT_W   = 8
) (
  input  logic [DATA_W-1:0]  data,
  input  sertx_lc_t          lc,
  output logic [FRAME_W-1:0] frame_vec,
  output logic [CNT_W-1:0]   data_ticks,
  output logic [CNT_W-1:0]   tot_ticks
);

  int   nbits;
  int   slots;
  int   stop_t;
  logic par;
  logic pbit;

  always_comb begin
    nbits = DATA_W - 3 + int'(lc.wlen);
    par   = 1'b0;
    frame_vec = '1;
    frame_vec[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nbits) begin
        frame_vec[i+1] = data[i];
        par = par ^ data[i];
      end
    end
    if (lc.par_stick) pbit = ~lc.par_even;
    else              pbit = lc.par_even ? par : ~par;
    for (int j = 1; j < FRAME_W; j++) begin
      if (lc.par_en && (j == nbits + 1)) frame_vec[j] = pbit;
    end
    slots = 1 + nbits + (lc.par_en ? 1 : 0);
    if (!lc.stop2)           stop_t = OVS;
    else if (lc.wlen == 2'd0) stop_t = OVS + OVS / 2;
    else                     stop_t = 2 * OVS;
    data_ticks = CNT_W'(slots * OVS);
    tot_ticks  = CNT_W'(slots * OVS + stop_t);
  end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int OVS     = 16,
  parameter int FRAME_W = 10,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               hold_full,
  input  logic               brk,
  input  logic [FRAME_W-1:0] frame_vec,
  input  logic [CNT_W-1:0]   data_ticks,
  input  logic [CNT_W-1:0]   tot_ticks,
  output logic               xfer,
  output logic               sout,
  output logic               temt
);

  logic               busy;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cnt_inc;
  logic [CNT_W-1:0]   slot;
  logic [FRAME_W-1:0] vec_q;
  logic [CNT_W-1:0]   dt_q;
  logic [CNT_W-1:0]   tt_q;
  logic               line_q;
  logic               line_n;
  logic               last;
  logic               sel_bit;

  always_comb begin
    cnt_inc = cnt + 1'b1;
    last    = busy && (cnt_inc == tt_q);
    xfer    = tick && hold_full && (!busy || last);
    slot    = cnt_inc / CNT_W'(OVS);
    sel_bit = 1'b1;
    for (int i = 0; i < FRAME_W; i++) begin
      if (slot == CNT_W'(i)) sel_bit = vec_q[i];
    end
    if (xfer)              line_n = 1'b0;
    else if (tick && busy) line_n = last ? 1'b1 : ((cnt_inc < dt_q) ? sel_bit : 1'b1);
    else                   line_n = line_q;
  end

  always_ff @(posedge clk) begin
    if (xfer) begin
      vec_q <= frame_vec;
      dt_q  <= data_ticks;
      tt_q  <= tot_ticks;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      line_q <= 1'b1;
      sout   <= 1'b1;
      temt   <= 1'b1;
    end else begin
      line_q <= line_n;
      sout   <= brk ? 1'b0 : line_n;
      if (xfer) begin
        busy <= 1'b1;
        cnt  <= '0;
        temt <= 1'b0;
      end else if (tick && busy) begin
        if (last) begin
          busy <= 1'b0;
          cnt  <= '0;
          temt <= 1'b1;
        end else begin
          cnt <= cnt_inc;
        end
      end
    end
  end

endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wlen,
  input  logic              stop2,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              brk,
  output logic              sout,
  output logic              thre,
  output logic              temt
);

  localparam int FRAME_W   = DATA_W + 2;
  localparam int MAX_TICKS = (FRAME_W + 2) * OVS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  sertx_lc_t          lc;
  logic [DATA_W-1:0]  hold_data;
  logic [FRAME_W-1:0] frame_vec;
  logic [CNT_W-1:0]   data_ticks;
  logic [CNT_W-1:0]   tot_ticks;
  logic               xfer;

  assign lc = '{wlen: wlen, stop2: stop2, par_en: par_en,
                par_even: par_even, par_stick: par_stick};

  sertx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .xfer      (xfer),
    .hold_data (hold_data),
    .thre      (thre)
  );

  sertx_framer #(
    .DATA_W(DATA_W), .OVS(OVS), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
  ) i_framer (
    .data       (hold_data),
    .lc         (lc),
    .frame_vec  (frame_vec),
    .data_ticks (data_ticks),
    .tot_ticks  (tot_ticks)
  );

  sertx_shifter #(
    .OVS(OVS), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
  ) i_shift (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick16),
    .hold_full  (~thre),
    .brk        (brk),
    .frame_vec  (frame_vec),
    .data_ticks (data_ticks),
    .tot_ticks  (tot_ticks),
    .xfer       (xfer),
    .sout       (sout),
    .temt       (temt)
  );

endmodule

// File: rtl/sertx_dbuf_chk.sv
module sertx_dbuf_chk (
  input logic clk,
  input logic rst,
  input logic tick16,
  input logic wr_en,
  input logic brk,
  input logic sout,
  input logic thre,
  input logic temt
);

  // R2
  wr_clears_thre_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !thre);

  // R3
  thre_rise_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(thre) |-> ($past(tick16) && !temt));

  // R3
  temt_fall_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(temt) |-> ($past(!thre) && $past(tick16)));

  // R5
  temt_rise_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(temt) |-> (thre && $past(tick16)));

  // R10
  brk_low_chk: assert property (@(posedge clk) disable iff (rst)
    brk |=> !sout);

  // R6
  sout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick16 && !brk && !$past(brk)) |=> $stable(sout));

endmodule

bind sertx_dbuf sertx_dbuf_chk i_chk (
  .clk    (clk),
  .rst    (rst),
  .tick16 (tick16),
  .wr_en  (wr_en),
  .brk    (brk),
  .sout   (sout),
  .thre   (thre),
  .temt   (temt)
);

// File: tb/test_sertx_dbuf.sv
module test_sertx_dbuf;

  localparam int CLK_P = 10;

  typedef struct packed {
    logic [7:0] d;
    logic [1:0] wl;
    logic       s2;
    logic       pe;
    logic       pev;
    logic       pst;
  } exp_t;

  logic       clk, rst, tick16, wr_en, stop2, par_en, par_even, par_stick, brk;
  logic [7:0] wr_data;
  logic [1:0] wlen;
  logic       sout, thre, temt;

  int   checks = 0;
  int   errors = 0;
  int   tick_total = 0;
  logic mon_en = 1'b1;
  exp_t sb[$];

  sertx_dbuf i_sertx_dbuf (
    .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .wlen(wlen), .stop2(stop2), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .brk(brk), .sout(sout), .thre(thre), .temt(temt)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  initial begin
    tick16 = 1'b0;
    forever begin
      @(negedge clk);
      tick16 = ~tick16;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (tick16) tick_total++;
    end
  end

  function automatic int nb(exp_t e);
    return 5 + int'(e.wl);
  endfunction

  function automatic int exp_tot(exp_t e);
    int st;
    if (!e.s2)         st = 16;
    else if (e.wl == 0) st = 24;
    else               st = 32;
    return 16 * (1 + nb(e) + (e.pe ? 1 : 0)) + st;
  endfunction

  function automatic logic exp_lvl(exp_t e, int k);
    int   slot = k / 16;
    logic p = 1'b0;
    for (int i = 0; i < nb(e); i++) p ^= e.d[i];
    if (slot == 0) return 1'b0;
    if (slot <= nb(e)) return e.d[slot-1];
    if (e.pe && slot == nb(e) + 1) return e.pst ? ~e.pev : (e.pev ? p : ~p);
    return 1'b1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: queue expected frame, then pulse the write strobe
  task automatic send(logic [7:0] d);
    exp_t e;
    e = '{d: d, wl: wlen, s2: stop2, pe: par_en, pev: par_even, pst: par_stick};
    sb.push_back(e);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_bit(input int which, output int ok);
    ok = 0;
    for (int n = 0; n < 2000; n++) begin
      if ((which == 0 && thre) || (which == 1 && temt && thre)) begin
        ok = 1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic pair(logic [7:0] a, logic [7:0] b, string req);
    int ok;
    send(a);
    wait_bit(0, ok);
    chk({req, " first transfer"}, ok, 1);
    send(b);
    wait_bit(1, ok);
    chk({req, " pair drained"}, ok, 1);
    repeat (4) @(negedge clk);
  endtask

  // Monitor: compares every tick of each frame against the scoreboard
  initial begin
    exp_t cur;
    logic active = 1'b0;
    logic mism = 1'b0;
    int   k = 0;
    int   bad_k = 0;
    logic t;
    forever begin
      @(posedge clk);
      t = tick16;
      @(negedge clk);
      if (t && mon_en) begin
        if (active) begin
          k++;
          if (k == exp_tot(cur)) begin
            checks++;
            if (mism) begin
              errors++;
              $display("FAIL R6 R7 R8 R9 frame d=%02h: line wrong at tick %0d actual=%0b expected=%0b",
                       cur.d, bad_k, ~exp_lvl(cur, bad_k), exp_lvl(cur, bad_k));
            end
            active = 1'b0;
          end else if (sout !== exp_lvl(cur, k)) begin
            if (!mism) bad_k = k;
            mism = 1'b1;
          end
        end
        if (!active && sout == 1'b0) begin
          if (sb.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R6 unexpected start bit: actual=1 expected=0 frames");
          end else begin
            cur = sb.pop_front();
            active = 1'b1;
            k = 0;
            mism = 1'b0;
          end
        end
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ok;
    int t0;
    int t1;
    int temt_hi;
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; wlen = 2'd3; stop2 = 1'b0;
    par_en = 1'b0; par_even = 1'b0; par_stick = 1'b0; brk = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 sout in reset", int'(sout), 1);
    chk("R1 thre in reset", int'(thre), 1);
    chk("R1 temt in reset", int'(temt), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sout after reset", int'(sout), 1);
    chk("R1 status after reset", int'({thre, temt}), 3);

    // Single write then queued write (8N1, 160 ticks per frame)
    send(8'hA3);
    chk("R2 thre low after write", int'(thre), 0);
    chk("R2 temt unchanged by write", int'(temt), 1);
    wait_bit(0, ok);
    chk("R3 transfer happened", ok, 1);
    chk("R3 temt low at transfer", int'(temt), 0);
    chk("R3 start bit at transfer", int'(sout), 0);
    t0 = tick_total;
    send(8'h5C);
    temt_hi = 0;
    for (int n = 0; n < 2000 && !thre; n++) begin
      @(negedge clk);
      if (temt) temt_hi = 1;
    end
    chk("R4 queued transfer at frame end", tick_total - t0, 160);
    chk("R4 temt stays low while queued", temt_hi, 0);
    chk("R4 next start bit", int'(sout), 0);
    t1 = tick_total;
    for (int n = 0; n < 2000 && !temt; n++) @(negedge clk);
    chk("R5 temt rise tick", tick_total - t1, 160);
    chk("R5 thre high when temt rises", int'(thre), 1);
    repeat (4) @(negedge clk);

    // Formats: each as a back-to-back pair
    wlen = 2'd0; stop2 = 1'b1;
    pair(8'hF5, 8'hEA, "R9 R6 5-bit 1.5 stop");
    wlen = 2'd1; stop2 = 1'b0; par_en = 1'b1; par_even = 1'b0;
    pair(8'h2D, 8'hC3, "R7 odd parity 6-bit");
    wlen = 2'd2; stop2 = 1'b1; par_even = 1'b1;
    pair(8'h7F, 8'h81, "R7 R9 even parity 7-bit 2 stop");
    wlen = 2'd3; stop2 = 1'b0; par_stick = 1'b1; par_even = 1'b1;
    pair(8'hFF, 8'h00, "R8 stick parity low");
    par_even = 1'b0;
    pair(8'h01, 8'h80, "R8 stick parity high");
    par_en = 1'b0; par_stick = 1'b0; stop2 = 1'b1;
    pair(8'hA5, 8'h5A, "R9 8-bit 2 stop");

    // Break while idle
    mon_en = 1'b0;
    brk = 1'b1;
    @(negedge clk);
    chk("R10 sout low under break", int'(sout), 0);
    repeat (5) @(negedge clk);
    chk("R10 sout held low", int'(sout), 0);
    brk = 1'b0;
    @(negedge clk);
    chk("R10 sout restored", int'(sout), 1);
    repeat (2) @(negedge clk);
    mon_en = 1'b1;

    chk("R6 all queued frames seen", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule